// File: doc/BRIEF.md
# Odd-Ratio Clock Divider (Divide by Seven)

This block derives a slower clock from a fast reference: every seven reference periods it emits one output period. A counter advances on each rising reference edge, wraps after seven counts, and a registered level follows the count. It sets the level high at the start of each period and drops it after the programmed number of high cycles.

Two duty shapes are available through a select input. The single-edge shape uses only rising edges, so the high phase is three reference periods and the low phase is four. The balanced shape adds a register clocked on the falling reference edge. That register holds the high level for an extra half period, which gives an exact 50% duty cycle (3.5 high, 3.5 low). The select is captured only when a new output period begins, so switching between shapes never shortens or splits a pulse.

An active-high asynchronous reset forces the output low and parks the counter. On the first rising reference edge after release the output goes high, starting period zero.

Top module: `div7_clkgen`

## Requirements
- R1: The output period is exactly 7 `clk_in` periods in both duty shapes. Each output rising edge follows a `clk_in` rising edge.
- R2: With `duty_sel` = 0 (single-edge shape), `clk_out` is high for 3 `clk_in` periods and low for 4.
- R3: With `duty_sel` = 1 (balanced shape), `clk_out` rises on a `clk_in` rising edge and falls on the `clk_in` falling edge 3.5 periods later, giving 3.5 periods high and 3.5 low.
- R4: `duty_sel` is sampled only on the rising edge that starts an output period. A change at any other point has no effect on `clk_out` until the next period starts.
- R5: While `rst` is high, `clk_out` is low. Asserting `rst` drives it low at once, without waiting for a clock edge.
- R6: After `rst` falls, `clk_out` stays low until the first `clk_in` rising edge. At that edge it rises and period zero begins.
- R7: `clk_out` is formed only from registered signals. The falling-edge stretch register is never set while the captured shape is single-edge, so a change of shape produces no extra or runt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Reference clock to be divided |
| rst | input | 1 | Asynchronous reset, active high |
| duty_sel | input | 1 | Duty shape: 0 = 3/7 single-edge, 1 = 50% balanced |
| clk_out | output | 1 | Divided clock, period 7 × `clk_in` |

## Verification
The properties assume that `duty_sel` is synchronous to `clk_in` and meets setup at the rising edge. They also assume that `rst` is released away from a rising edge, so the counter's first step is a clean wrap to count zero. The stimulus changes `duty_sel` only just after a falling edge, at every phase of the period in turn. It asserts and releases `rst` midway between edges. The expected waveform is computed from the phase index at half-period resolution.

// File: rtl/div7_pkg.sv
package div7_pkg;

    typedef enum logic {
        DUTY_SINGLE   = 1'b0,
        DUTY_BALANCED = 1'b1
    } duty_shape_e;

    localparam int unsigned DIV_RATIO_DEF  = 7;
    localparam int unsigned HIGH_COUNT_DEF = 3;

    typedef struct packed {
        logic        rise_lvl;
        duty_shape_e shape;
    } level_state_t;

    function automatic int unsigned cnt_width(input int unsigned ratio);
        return (ratio <= 2) ? 1 : $clog2(ratio);
    endfunction

endpackage

// File: rtl/div7_phase_counter.sv
module div7_phase_counter #(
    parameter int unsigned RATIO = div7_pkg::DIV_RATIO_DEF,
    parameter int unsigned CW    = div7_pkg::cnt_width(RATIO)
) (
    input  logic          clk_in,
    input  logic          rst,
    output logic [CW-1:0] phase,
    output logic [CW-1:0] phase_nxt
);
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    always_comb begin
        if (phase == LAST) begin
            phase_nxt = '0;
        end else begin
            phase_nxt = phase + 1'b1;
        end
    end

    always_ff @(posedge clk_in or posedge rst) begin
        if (rst) begin
            phase <= LAST;
        end else begin
            phase <= phase_nxt;
        end
    end
endmodule

// File: rtl/div7_level_gen.sv
module div7_level_gen
    import div7_pkg::*;
#(
    parameter int unsigned HIGH_COUNT = HIGH_COUNT_DEF,
    parameter int unsigned CW         = 3
) (
    input  logic          clk_in,
    input  logic          rst,
    input  logic [CW-1:0] phase_nxt,
    input  logic          duty_sel,
    output level_state_t  state_q
);
    localparam logic [CW-1:0] HIGH_LIM = CW'(HIGH_COUNT);

    level_state_t state_d;

    always_comb begin
        state_d          = state_q;
        state_d.rise_lvl = (phase_nxt < HIGH_LIM);
        if (phase_nxt == '0) begin
            state_d.shape = duty_shape_e'(duty_sel);
        end
    end

    always_ff @(posedge clk_in or posedge rst) begin
        if (rst) begin
            state_q <= '{rise_lvl: 1'b0, shape: DUTY_SINGLE};
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/div7_half_stretch.sv
module div7_half_stretch
    import div7_pkg::*;
(
    input  logic        clk_in,
    input  logic        rst,
    input  logic        rise_lvl,
    input  duty_shape_e shape,
    output logic        fall_lvl
);
    always_ff @(negedge clk_in or posedge rst) begin
        if (rst) begin
            fall_lvl <= 1'b0;
        end else begin
            fall_lvl <= rise_lvl && (shape == DUTY_BALANCED);
        end
    end
endmodule

// File: rtl/div7_clkgen.sv
module div7_clkgen
    import div7_pkg::*;
#(
    parameter int unsigned RATIO      = DIV_RATIO_DEF,
    parameter int unsigned HIGH_COUNT = HIGH_COUNT_DEF
) (
    input  logic clk_in,
    input  logic rst,
    input  logic duty_sel,
    output logic clk_out
);
    localparam int unsigned CW = cnt_width(RATIO);

    logic [CW-1:0] phase;
    logic [CW-1:0] phase_nxt;
    level_state_t  lvl_q;
    logic          fall_lvl;

    div7_phase_counter #(.RATIO(RATIO), .CW(CW)) u_cnt (
        .clk_in    (clk_in),
        .rst       (rst),
        .phase     (phase),
        .phase_nxt (phase_nxt)
    );

    div7_level_gen #(.HIGH_COUNT(HIGH_COUNT), .CW(CW)) u_lvl (
        .clk_in    (clk_in),
        .rst       (rst),
        .phase_nxt (phase_nxt),
        .duty_sel  (duty_sel),
        .state_q   (lvl_q)
    );

    div7_half_stretch u_str (
        .clk_in   (clk_in),
        .rst      (rst),
        .rise_lvl (lvl_q.rise_lvl),
        .shape    (lvl_q.shape),
        .fall_lvl (fall_lvl)
    );

    assign clk_out = lvl_q.rise_lvl | fall_lvl;
endmodule

// File: rtl/div7_clkgen_chk.sv
module div7_clkgen_chk #(
    parameter int unsigned RATIO = 7,
    parameter int unsigned CW    = 3
) (
    input logic          clk_in,
    input logic          rst,
    input logic          clk_out,
    input logic [CW-1:0] phase,
    input logic          rise_lvl,
    input logic          shape_q,
    input logic          fall_lvl
);
    // R1: the phase count stays inside the period and wraps after the last step
    p_phase_range_r1: assert property (@(posedge clk_in) disable iff (rst)
        phase < CW'(RATIO));
    p_phase_wrap_r1: assert property (@(posedge clk_in) disable iff (rst)
        (phase == CW'(RATIO - 1)) |=> (phase == '0));

    // R1: a rising output level only ever starts at phase zero
    p_rise_at_zero_r1: assert property (@(posedge clk_in) disable iff (rst)
        $rose(rise_lvl) |-> (phase == '0));

    // R4: the captured shape cannot change except where a period starts
    p_shape_hold_r4: assert property (@(posedge clk_in) disable iff (rst)
        (phase != '0) |-> (shape_q == $past(shape_q)));

    // R7: the stretch register is set only under the balanced shape
    p_stretch_gated_r7: assert property (@(posedge clk_in) disable iff (rst)
        fall_lvl |-> shape_q);

    // R5: reset holds the output low
    always @(negedge clk_in) begin
        if (rst) begin
            a_reset_low_r5: assert (!clk_out);
        end
    end
endmodule

bind div7_clkgen div7_clkgen_chk #(.RATIO(RATIO), .CW(CW)) u_chk (
    .clk_in   (clk_in),
    .rst      (rst),
    .clk_out  (clk_out),
    .phase    (phase),
    .rise_lvl (lvl_q.rise_lvl),
    .shape_q  (lvl_q.shape),
    .fall_lvl (fall_lvl)
);

// File: tb/test_div7_clkgen.sv
`timescale 1ns/1ps
module test_div7_clkgen;
    logic clk_in = 1'b0;
    logic rst    = 1'b1;
    logic duty_sel = 1'b0;
    logic clk_out;

    int n_vec  = 0;
    int n_fail = 0;
    int k      = 0;     // rising edges since reset release
    bit shape_eff = 1'b0;
    bit done = 1'b0;

    always #10 clk_in = ~clk_in;   // 50 MHz

    div7_clkgen i_div7_clkgen (
        .clk_in   (clk_in),
        .rst      (rst),
        .duty_sel (duty_sel),
        .clk_out  (clk_out)
    );

    task automatic chk(input logic exp, input string req);
        n_vec++;
        if (clk_out !== exp) begin
            n_fail++;
            $display("FAIL %s: k=%0d clk_out=%b expected=%b", req, k, clk_out, exp);
        end
    endtask

    // one reference cycle: sample in both halves, optionally drive duty_sel late
    task automatic step(input bit drive, input bit val);
        int p;
        bit e1, e2;
        @(posedge clk_in);
        k++;
        p = (k - 1) % 7;
        if (p == 0) shape_eff = duty_sel;   // R4 capture point
        e1 = (p < 3) || (shape_eff && p == 3);
        e2 = (p < 3);
        #5;
        chk(e1, shape_eff ? "R3/R1 first half" : "R2/R1 first half");
        #10;
        chk(e2, shape_eff ? "R3 second half" : "R2 second half");
        #2;
        if (drive) duty_sel = val;
    endtask

    initial begin
        #300000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R5 reset state
        repeat (3) @(posedge clk_in);
        #5;
        chk(1'b0, "R5 reset level");
        #7;
        rst = 1'b0;
        #1;
        chk(1'b0, "R6 low before first edge");

        // R2 single-edge shape for several periods
        for (int i = 0; i < 21; i++) step(1'b0, 1'b0);

        // R3 balanced shape: request, then sweep periods
        duty_sel = 1'b1;
        for (int i = 0; i < 21; i++) step(1'b0, 1'b0);

        // R4 change shape at every phase of a period, both directions
        for (int ph = 0; ph < 7; ph++) begin
            for (int c = 0; c < 14; c++) begin
                step((c % 7) == ph, ~duty_sel);
            end
        end

        // R5 asynchronous reset in the middle of a high phase
        while (((k) % 7) != 1) step(1'b0, 1'b0);
        @(posedge clk_in);
        #3;
        rst = 1'b1;
        #2;
        chk(1'b0, "R5 async reset drop");
        repeat (2) @(posedge clk_in);
        #12;
        rst = 1'b0;
        k = 0;
        #1;
        chk(1'b0, "R6 low after release");
        duty_sel = 1'b1;
        for (int i = 0; i < 28; i++) step(1'b0, 1'b0);

        // R7 balanced to single-edge switch: no extra pulse
        duty_sel = 1'b0;
        for (int i = 0; i < 21; i++) step(1'b0, 1'b0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule